// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block sits after the comparator bank of a flash converter. It takes the 2^N-1 comparator outputs, which form a thermometer code, and returns the N-bit count that the code stands for. Bit 0 of the input is the lowest comparator. A clean code of value m has bits 0..m-1 set and all higher bits clear.

The conversion has two stages. First, a row of three-input cells finds the top edge of the code. Cell i looks at bit i and the two bits above it, and pulls its active-low line low only for the pattern "1, 0, 0". Because the window spans two bits above the candidate edge, a single misplaced comparator bit cannot open a second edge. Second, a shared AND tree over the active-low lines forms the binary result, and each output bit is the NAND of the odd-numbered blocks at its own level. An optional register stage adds one cycle of latency and carries a valid flag. Without it the path is purely combinational.

Top module: `therm_enc_top`

## Requirements
- R1: With valid_i high, a clean thermometer code whose lowest m bits are set (m from 0 to 2^N-1) yields bin_o = m.
- R2: With valid_i high, an input of all ones yields bin_o = 2^N-1.
- R3: For any clean code, or any code with one order-1 bubble as defined in R4 and R6, at most one active-low edge line is low.
- R4: A clean code of count m with one bit p cleared, where p <= m-2, yields bin_o = m.
- R5: With valid_i high, an input of all zeros yields bin_o = 0.
- R6: A clean code of count m with bit m+1 set as well, where m+1 <= 2^N-2, yields bin_o = m+2.
- R7: With the register stage enabled (the default), bin_o and valid_o show the result for the input one clock edge later, and valid_o equals valid_i from the previous edge.
- R8: With the register stage enabled, an edge at which valid_i is low leaves bin_o unchanged, whatever therm_i carries.
- R9: Driving rst_ni low clears bin_o and valid_o to 0 at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks therm_i as a sample to encode |
| therm_i | input | 2^NBITS-1 | Comparator outputs; bit 0 is the lowest threshold |
| valid_o | output | 1 | Marks bin_o as holding a fresh result |
| bin_o | output | NBITS | Binary count |

## Verification
The single-line assertion applies only when valid_i is high, and it assumes that therm_i is then either a clean code or a code with one order-1 bubble: one cleared bit at least two places below the edge, or one extra set bit one gap above it. A stray bit further from the edge is a higher-order error, and for such an input two lines may legally go low. The stimulus therefore builds every valid sample from a count plus at most one bubble of those two shapes. Arbitrary patterns are driven only in cycles where valid_i is low, which also exercises the hold behaviour.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;
  function automatic int therm_w(input int nbits);
    return (1 << nbits) - 1;
  endfunction
endpackage

// File: rtl/therm_cell.sv
// Edge cell: low only on the pattern a=1, b=0, c=0.
module therm_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic y_no
);
  assign y_no = ~(a_i & ~b_i & ~c_i);
endmodule

// File: rtl/therm_onehot.sv
module therm_onehot #(
  parameter int NBITS = 3
) (
  input  logic [therm_enc_pkg::therm_w(NBITS)-1:0] therm_i,
  output logic [therm_enc_pkg::therm_w(NBITS)-1:0] oh_no
);
  localparam int THERM_W = therm_enc_pkg::therm_w(NBITS);

  // two zero guard bits above the top comparator
  logic [THERM_W+1:0] ext;
  assign ext = {2'b00, therm_i};

  for (genvar i = 0; i < THERM_W; i++) begin : g_cell
    therm_cell u_cell (
      .a_i  (ext[i]),
      .b_i  (ext[i+1]),
      .c_i  (ext[i+2]),
      .y_no (oh_no[i])
    );
  end
endmodule

// File: rtl/onehot_tree.sv
// Level l block b covers values b*2^l .. b*2^l+2^l-1; value v is line v-1.
// Block 0 (containing value 0) is never needed, so it is never built.
module onehot_tree #(
  parameter int NBITS = 3
) (
  input  logic [therm_enc_pkg::therm_w(NBITS)-1:0] oh_ni,
  output logic [NBITS-1:0]                         bin_o
);
  for (genvar l = 0; l < NBITS; l++) begin : g_lvl
    localparam int K = 1 << (NBITS - l);
    logic [K-1:1]   nd;
    logic [K/2-1:0] odd_n;

    if (l == 0) begin : g_leaf
      assign nd = oh_ni;
    end else begin : g_node
      for (genvar b = 1; b < K; b++) begin : g_blk
        assign nd[b] = g_lvl[l-1].nd[2*b] & g_lvl[l-1].nd[2*b+1];
      end
    end

    for (genvar i = 0; i < K/2; i++) begin : g_odd
      assign odd_n[i] = nd[2*i+1];
    end
    assign bin_o[l] = ~&odd_n;
  end
endmodule

// File: rtl/therm_enc_top.sv
module therm_enc_top #(
  parameter int NBITS   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     valid_i,
  input  logic [therm_enc_pkg::therm_w(NBITS)-1:0] therm_i,
  output logic                                     valid_o,
  output logic [NBITS-1:0]                         bin_o
);
  localparam int THERM_W = therm_enc_pkg::therm_w(NBITS);

  logic [THERM_W-1:0] oh_n;
  logic [NBITS-1:0]   bin_c;

  therm_onehot #(.NBITS(NBITS)) u_onehot (
    .therm_i (therm_i),
    .oh_no   (oh_n)
  );

  onehot_tree #(.NBITS(NBITS)) u_tree (
    .oh_ni (oh_n),
    .bin_o (bin_c)
  );

  AST_SINGLE_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $onehot0(~oh_n)); // R3
  AST_ALL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && therm_i == '0) |-> bin_c == '0); // R5
  AST_ALL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && &therm_i) |-> bin_c == NBITS'(THERM_W)); // R2

  if (REG_OUT) begin : g_reg
    logic [NBITS-1:0] bin_q;
    logic             valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bin_q   <= '0;
        valid_q <= 1'b0;
      end else begin
        valid_q <= valid_i;
        if (valid_i) bin_q <= bin_c;
      end
    end

    assign bin_o   = bin_q;
    assign valid_o = valid_q;

    AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o); // R7
    AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o); // R7
    AST_DATA_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> bin_o == $past(bin_c)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(bin_o)); // R8
  end else begin : g_comb
    assign bin_o   = bin_c;
    assign valid_o = valid_i;
  end
endmodule

// File: tb/sim_therm_enc_top.sv
module sim_therm_enc_top;
  localparam int NBITS   = 3;
  localparam int THERM_W = (1 << NBITS) - 1;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic [THERM_W-1:0] therm_i = '0;
  logic               valid_o;
  logic [NBITS-1:0]   bin_o;

  int n_vec = 0;
  int n_bad = 0;

  logic [NBITS-1:0] exp_bin = '0;
  logic             exp_valid = 1'b0;
  string            pend_tag = "R9";

  always #4 clk = ~clk;

  therm_enc_top #(.NBITS(NBITS), .REG_OUT(1'b1)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .therm_i (therm_i),
    .valid_o (valid_o),
    .bin_o   (bin_o)
  );

  // reference: one above the index of the highest set bit
  function automatic logic [NBITS-1:0] ref_count(input logic [THERM_W-1:0] t);
    int r = 0;
    for (int i = 0; i < THERM_W; i++) if (t[i]) r = i + 1;
    return NBITS'(r);
  endfunction

  function automatic logic [THERM_W-1:0] clean(input int m);
    return THERM_W'((1 << m) - 1);
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (bin_o !== exp_bin || valid_o !== exp_valid) begin
      n_bad++;
      $display("FAIL %s: bin_o=%0d valid_o=%0b expected bin_o=%0d valid_o=%0b",
               tag, bin_o, valid_o, exp_bin, exp_valid);
    end
  endtask

  // compare the previous vector, then drive this one and update the model
  task automatic apply(input logic v, input logic [THERM_W-1:0] t, input string tag);
    @(negedge clk);
    compare(pend_tag);
    valid_i = v;
    therm_i = t;
    exp_valid = v;
    if (v) exp_bin = ref_count(t);
    pend_tag = tag;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R9 reset state");
    rst_ni = 1'b1;

    apply(1'b1, '0, "R5 all zero");
    for (int m = 0; m <= THERM_W; m++) apply(1'b1, clean(m), "R1 clean code");
    apply(1'b1, '1, "R2 all ones");
    apply(1'b1, clean(4), "R7 back-to-back");
    apply(1'b1, clean(1), "R7 back-to-back");

    // R4: cleared bit well below the edge
    for (int m = 2; m <= THERM_W; m++)
      for (int p = 0; p <= m - 2; p++)
        apply(1'b1, clean(m) & ~(THERM_W'(1) << p), "R4 zero bubble");

    // R6: stray set bit one gap above the edge
    for (int m = 0; m + 1 <= THERM_W - 1; m++)
      apply(1'b1, clean(m) | (THERM_W'(1) << (m + 1)), "R6 one bubble");

    // R3 is covered by the mix of R1, R4 and R6 above; confirm a final edge case
    apply(1'b1, 7'b1011111, "R3 bubble next to top");

    // R8: idle cycles with noise on therm_i
    apply(1'b0, 7'b1010101, "R8 idle hold");
    apply(1'b0, 7'b0001000, "R8 idle hold");
    apply(1'b0, '1, "R8 idle hold");
    apply(1'b1, clean(3), "R7 resume");
    apply(1'b1, clean(6), "R7 resume");

    // R9: reset asserted between edges clears outputs at once
    @(negedge clk);
    compare(pend_tag);
    #2 rst_ni = 1'b0;
    #1;
    exp_bin = '0;
    exp_valid = 1'b0;
    compare("R9 async clear");
    valid_i = 1'b0;
    @(negedge clk);
    compare("R9 held in reset");
    rst_ni = 1'b1;
    pend_tag = "R9 after release";
    apply(1'b1, clean(5), "R1 after reset");
    apply(1'b0, '0, "R8 idle hold");
    @(negedge clk);
    compare(pend_tag);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule